// File: doc/BRIEF.md
# Cascadable Up/Down/Load Counter Chain

This block is a synchronous counter built from identical 4-bit slices. Each slice can load a parallel value, count up, count down or hold. A two-bit select code and an active-low chain enable choose what it does. Every slice has an active-low carry output that feeds the enable of the next more significant slice. No gating sits between slices, so any number of slices form one wide counter that changes on a single shared clock edge.

The carry output is combinational. It is driven low when the enable is low and the slice sits at the terminal value for the selected direction: all ones when counting up, zero when counting down. It is also low while load is selected. A carry can therefore ripple through the whole chain within one cycle. The outermost enable is tied low for free-running counting. A synchronous active-low reset clears the count and takes priority over every mode. A parameter sets the number of slices; the default of three gives 12 bits.

Top module: `chain_counter`

## Requirements
- R1: With `sel` = 2'b00 (load), the next rising edge copies `load_data` into `count`, whatever the level of `cin_n`.
- R2: With `sel` = 2'b01 (up) and `cin_n` low, each edge adds one to the full chained `count`, carrying between slices (0x00F becomes 0x010) and wrapping from all ones to 0.
- R3: With `sel` = 2'b10 (down) and `cin_n` low, each edge subtracts one from the full chained `count`, borrowing between slices (0x010 becomes 0x00F) and wrapping from 0 to all ones.
- R4: With `sel` = 2'b01 or 2'b10 and `cin_n` high, `count` keeps its value.
- R5: With `sel` = 2'b11, `count` keeps its value whatever the level of `cin_n`.
- R6: `cout_n` is low in the same cycle when `cin_n` is low and `count` is all ones under `sel` = 2'b01, or zero under `sel` = 2'b10. In hold, with `cin_n` high, or away from the terminal value it is high, and it follows a change of `cin_n` without waiting for a clock edge.
- R7: `cout_n` is low whenever `sel` = 2'b00, whatever the values of `count` and `cin_n`.
- R8: With `rst_n` low at a rising edge, `count` becomes 0 whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock, never gated |
| rst_n | input | 1 | Synchronous active-low reset of the count |
| sel | input | 2 | Mode select: 00 load, 01 up, 10 down, 11 hold |
| cin_n | input | 1 | Active-low count enable into the least significant slice |
| load_data | input | NUM_SLICES*SLICE_W (12) | Parallel value taken in load mode |
| count | output | NUM_SLICES*SLICE_W (12) | Current chained count |
| cout_n | output | 1 | Active-low carry out of the most significant slice |

## Verification
The hardest case to reach from the ports is a carry or borrow that crosses slice boundaries: an upper slice may change only when every lower slice sits at its terminal value in the same cycle. Instead of counting up thousands of times, the stimulus loads values next to those boundaries (0x00F, 0xFFE, 0x001) and then steps up and down across them. The bench also changes `cin_n` with no clock edge between, at a full-ones count, to show that the carry output responds at once.

// File: rtl/cnt_pkg.sv
// Shared mode codes and internal action type for the chained counter.
package cnt_pkg;

    // Select codes seen at the ports (bit 1 and bit 0 of sel).
    localparam logic [1:0] SEL_LOAD = 2'b00;
    localparam logic [1:0] SEL_UP   = 2'b01;
    localparam logic [1:0] SEL_DOWN = 2'b10;
    localparam logic [1:0] SEL_HOLD = 2'b11;

    // Action a slice performs at the next clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2,
        ACT_DEC  = 2'd3
    } act_e;

endpackage

// File: rtl/slice_mode_dec.sv
// Mode decoder: turns the select code and the active-low enable into the
// action for one slice. Assumes sel and cin_n are stable around the edge.
module slice_mode_dec
    import cnt_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       cin_n,
    output act_e       act
);

    // Load ignores the enable, counting needs it, hold code always holds.
    always_comb begin
        unique case (sel)
            SEL_LOAD: act = ACT_LOAD;
            SEL_UP:   act = cin_n ? ACT_HOLD : ACT_INC;
            SEL_DOWN: act = cin_n ? ACT_HOLD : ACT_DEC;
            default:  act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/count_slice.sv
// One counter slice: WIDTH-bit register with load/up/down/hold, wrapping
// modulo 2**WIDTH, plus a combinational active-low carry out for the next
// slice. Assumes one free-running clock shared by all slices.
module count_slice
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             cin_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             cout_n
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;

    act_e             act;
    logic [WIDTH-1:0] q_nxt;
    logic             at_top;
    logic             at_zero;

    slice_mode_dec u_dec (
        .sel   (sel),
        .cin_n (cin_n),
        .act   (act)
    );

    // Next-state selection from the decoded action.
    always_comb begin
        unique case (act)
            ACT_LOAD: q_nxt = din;
            ACT_INC:  q_nxt = q + ONE;
            ACT_DEC:  q_nxt = q - ONE;
            default:  q_nxt = q;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ZERO;
        else        q <= q_nxt;
    end

    // Terminal detection and carry out, low on terminal count or load.
    always_comb begin
        at_top  = (q == TOP);
        at_zero = (q == ZERO);
        cout_n  = !((sel == SEL_LOAD)
                 || (!cin_n && (sel == SEL_UP)   && at_top)
                 || (!cin_n && (sel == SEL_DOWN) && at_zero));
    end

    // R8: reset wins over every mode.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == ZERO));

    // R1: load takes the data input regardless of the enable.
    a_r1_load_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LOAD) |=> (q == $past(din)));

    // R2: enabled up step adds one, wrapping at the top.
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_UP) && !cin_n) |=> (q == $past(q) + ONE));

    // R3: enabled down step subtracts one, wrapping at zero.
    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_DOWN) && !cin_n) |=> (q == $past(q) - ONE));

    // R4: counting modes hold when the enable is high.
    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel[1] ^ sel[0]) && cin_n) |=> $stable(q));

    // R5: hold code keeps the value.
    a_r5_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HOLD) |=> $stable(q));

endmodule

// File: rtl/chain_counter.sv
// Chained synchronous counter: NUM_SLICES slices of SLICE_W bits, each
// slice's carry out driving the next slice's enable without extra gating.
// Assumes clk is never gated; counting is gated only through cin_n.
module chain_counter
    import cnt_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int SLICE_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    sel,
    input  logic                          cin_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] load_data,
    output logic [NUM_SLICES*SLICE_W-1:0] count,
    output logic                          cout_n
);

    localparam int TOTAL_W = NUM_SLICES * SLICE_W;

    logic [NUM_SLICES:0] carry_n;

    // Chain entry and exit of the ripple carry.
    always_comb begin
        carry_n[0] = cin_n;
        cout_n     = carry_n[NUM_SLICES];
    end

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        count_slice #(.WIDTH(SLICE_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .cin_n  (carry_n[g]),
            .din    (load_data[g*SLICE_W +: SLICE_W]),
            .q      (count[g*SLICE_W +: SLICE_W]),
            .cout_n (carry_n[g+1])
        );
    end

    // R6: full-width terminal count with enable low shows on the carry.
    a_r6_chain_carry_up: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_UP) && !cin_n && (&count)) |-> !cout_n);

    a_r6_chain_carry_down: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_DOWN) && !cin_n && (count == '0)) |-> !cout_n);

    // R6: a carry cannot appear while the whole chain is disabled.
    a_r6_no_carry_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cin_n && (sel != SEL_LOAD)) |-> cout_n);

    // R2: chained wrap from all ones to zero.
    a_r2_chain_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_UP) && !cin_n && (&count)) |=> (count == TOTAL_W'(0)));

    // R7: load forces the carry low.
    a_r7_load_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LOAD) |-> !cout_n);

endmodule

// File: tb/test_chain_counter.sv
// Bench for chain_counter with the default three slices (12 bits).
module test_chain_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  sel;
    logic        cin_n;
    logic [11:0] load_data;
    logic [11:0] count;
    logic        cout_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chain_counter i_chain_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .cin_n     (cin_n),
        .load_data (load_data),
        .count     (count),
        .cout_n    (cout_n)
    );

    // Row: {sel, cin_n, load_data, expected count after edge,
    //       expected cout_n after edge with same inputs, requirement number}
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {2'b00, 1'b1, 12'hFFE, 12'hFFE, 1'b0, 4'd1}, // R1 load, cin high; R7
        {2'b01, 1'b0, 12'h000, 12'hFFF, 1'b0, 4'd6}, // R2 up; R6 terminal up
        {2'b01, 1'b0, 12'h000, 12'h000, 1'b1, 4'd2}, // R2 wrap to zero
        {2'b10, 1'b0, 12'h000, 12'hFFF, 1'b1, 4'd3}, // R3 wrap to all ones
        {2'b10, 1'b0, 12'h000, 12'hFFE, 1'b1, 4'd3}, // R3 down
        {2'b00, 1'b0, 12'h00F, 12'h00F, 1'b0, 4'd7}, // R1 load, cin low; R7
        {2'b01, 1'b0, 12'h000, 12'h010, 1'b1, 4'd2}, // R2 carry into slice 1
        {2'b10, 1'b0, 12'h000, 12'h00F, 1'b1, 4'd3}, // R3 borrow from slice 1
        {2'b01, 1'b1, 12'h000, 12'h00F, 1'b1, 4'd4}, // R4 up disabled
        {2'b10, 1'b1, 12'h000, 12'h00F, 1'b1, 4'd4}, // R4 down disabled
        {2'b11, 1'b0, 12'h000, 12'h00F, 1'b1, 4'd5}, // R5 hold, cin low
        {2'b00, 1'b0, 12'h001, 12'h001, 1'b0, 4'd1}, // R1 load
        {2'b10, 1'b0, 12'h000, 12'h000, 1'b0, 4'd6}, // R6 terminal down
        {2'b11, 1'b1, 12'h000, 12'h000, 1'b1, 4'd5}, // R5 hold, cin high
        {2'b00, 1'b1, 12'h5A3, 12'h5A3, 1'b0, 4'd7}, // R7 load at mid value
        {2'b10, 1'b0, 12'h000, 12'h5A2, 1'b1, 4'd3}  // R3 plain down
    };

    task automatic check12(input string req, input logic [11:0] act,
                           input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s count actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cout_n actual %b expected %b", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        sel       = 2'b01;
        cin_n     = 1'b0;
        load_data = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check12("R8", count, 12'h000);   // R8 reset state while up selected
        rst_n = 1'b1;

        // Vector walk.
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][3:0]);
            sel       = VEC[i][31:30];
            cin_n     = VEC[i][29];
            load_data = VEC[i][28:17];
            @(posedge clk);
            @(negedge clk);
            check12(tag, count, VEC[i][16:5]);
            check1(tag, cout_n, VEC[i][4]);
        end

        // R6: carry follows cin_n with no clock edge in between.
        sel       = 2'b00;
        load_data = 12'hFFF;
        @(posedge clk);
        @(negedge clk);
        sel   = 2'b01;
        cin_n = 1'b1;
        #1;
        check1("R6", cout_n, 1'b1);
        cin_n = 1'b0;
        #0.5;
        check1("R6", cout_n, 1'b0);
        sel = 2'b11;
        #0.2;
        check1("R6", cout_n, 1'b1);       // R6 hold code never carries
        check12("R4", count, 12'hFFF);

        // R8: reset in the middle of a load takes priority.
        sel       = 2'b00;
        load_data = 12'h777;
        rst_n     = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check12("R8", count, 12'h000);
        rst_n = 1'b1;

        // R2: sixteen up steps from zero carry exactly once into slice 1.
        sel   = 2'b01;
        cin_n = 1'b0;
        repeat (16) @(posedge clk);
        @(negedge clk);
        check12("R2", count, 12'h010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule